// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is the lookup side of a two-way set-associative cache that stores 32-bit words and is addressed with 32-bit byte addresses. Each block holds two words. Each set keeps, per way, a tag, a valid flag and a dirty flag. A request strobe with an address reads both ways of the selected set at the same time. One clock later the block reports a response strobe, a hit flag, the dirty flag of the way that hit, and the word taken from that way.

All storage, for both metadata and data, is built from identical synchronous RAM slices that are 16K entries deep and 4 bits wide. The word-select bit of the address is appended to the set index to address the data slices. The metadata slices use only their lower half. A two-beat fill port writes a whole block into a chosen way, which lets a test environment preload the cache. After reset, a sequencer walks every set and clears all metadata. A busy output stays high while that clear runs and during the second beat of a fill.

Top module: `two_way_rd_cache`

## Requirements
- R1: The request address is split as tag = addr[31:16], set = addr[15:3], word select = addr[2]. Word select 0 returns the first word of the block and word select 1 returns the second.
- R2: A request is accepted when req_valid is high, busy is low and fill_start is low. Exactly one clock later rsp_valid is high for one cycle.
- R3: A way hits when its valid flag is set and its stored tag equals the request tag. rsp_hit is high if either way hits, and rsp_data is the word from the hitting way.
- R4: When there is no hit, or rsp_valid is low, rsp_hit, rsp_data and rsp_dirty are all zero.
- R5: From reset until 8192 clocks after reset is released, busy is high. When it drops, every lookup misses, including lookups of sets that were filled before the reset.
- R6: A request presented while busy is high, or in the same cycle as fill_start, is dropped, and rsp_valid stays low on the next cycle.
- R7: A fill is accepted when fill_start is high and busy is low. fill_blk is {tag, set}. fill_word0 is written to word select 0 in the accepting cycle and fill_word1 to word select 1 on the following cycle, with busy high during that second cycle. The written way gets valid = 1 and dirty = 0, so a hit on it reports rsp_dirty = 0.
- R8: A fill changes only the chosen way of the chosen set. The other way, and all other sets, keep their contents.
- R9: Both ways of one set can hold blocks with different tags, and either block can hit.
- R10: Address bits [1:0] have no effect on a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Byte address of the lookup |
| rsp_valid | output | 1 | Response strobe, one clock after an accepted request |
| rsp_hit | output | 1 | One of the two ways matched |
| rsp_dirty | output | 1 | Dirty flag of the matching way |
| rsp_data | output | 32 | Word read from the matching way, zero on a miss |
| fill_start | input | 1 | Start a two-beat block fill |
| fill_way | input | 1 | Way that receives the fill |
| fill_blk | input | 29 | Block address of the fill, {tag, set} |
| fill_word0 | input | 32 | Word written at word select 0 |
| fill_word1 | input | 32 | Word written at word select 1 |
| busy | output | 1 | Clear or fill in progress; requests and fills are refused |

## Verification
The assertions assume that the environment never fills the same tag into both ways of one set. When that holds, at most one way can match, and the checker requires the per-way hit vector to be one-hot or zero. The random phase of the bench reads its own model of the cache before each fill and skips any fill that would duplicate a tag already valid in the other way. Apart from that rule, requests and fills are driven freely, including while busy is high and in the same cycle as each other, because the refusal rules are part of the behaviour under test.

// File: rtl/cache_pkg.sv
package cache_pkg;
   localparam int unsigned CACHE_ADDR_W   = 32;
   localparam int unsigned CACHE_WORD_W   = 32;
   localparam int unsigned CACHE_SET_W    = 13;
   localparam int unsigned CACHE_SLICE_AW = 14;
   localparam int unsigned CACHE_SLICE_W  = 4;

   typedef enum logic [1:0] {
      PORT_LOOKUP = 2'd0,
      PORT_CLEAR  = 2'd1,
      PORT_FILL0  = 2'd2,
      PORT_FILL1  = 2'd3
   } port_use_e;
endpackage

// File: rtl/cache_ram_slice.sv
module cache_ram_slice #(
   parameter int unsigned AW = 14,
   parameter int unsigned DW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
      rdata <= cells[addr];
   end
endmodule

// File: rtl/cache_way.sv
module cache_way #(
   parameter int unsigned SET_W    = 13,
   parameter int unsigned META_W   = 18,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned SLICE_AW = 14,
   parameter int unsigned SLICE_W  = 4
) (
   input  logic              clk,
   input  logic              meta_we,
   input  logic              data_we,
   input  logic [SET_W-1:0]  set_idx,
   input  logic              word_sel,
   input  logic [META_W-1:0] meta_wdata,
   input  logic [WORD_W-1:0] word_wdata,
   output logic [META_W-1:0] meta_rdata,
   output logic [WORD_W-1:0] word_rdata
);
   localparam int unsigned META_SL  = (META_W + SLICE_W - 1) / SLICE_W;
   localparam int unsigned META_PAD = META_SL * SLICE_W;
   localparam int unsigned DATA_SL  = WORD_W / SLICE_W;

   logic [SLICE_AW-1:0] meta_addr, data_addr;
   logic [META_PAD-1:0] meta_wpad, meta_rpad;

   assign meta_addr = SLICE_AW'(set_idx);
   assign data_addr = SLICE_AW'({set_idx, word_sel});

   always_comb begin
      meta_wpad = '0;
      meta_wpad[META_W-1:0] = meta_wdata;
   end

   for (genvar m = 0; m < META_SL; m++) begin : g_meta
      cache_ram_slice #(.AW(SLICE_AW), .DW(SLICE_W)) u_slice (
         .clk   (clk),
         .we    (meta_we),
         .addr  (meta_addr),
         .wdata (meta_wpad[m*SLICE_W +: SLICE_W]),
         .rdata (meta_rpad[m*SLICE_W +: SLICE_W])
      );
   end

   for (genvar d = 0; d < DATA_SL; d++) begin : g_data
      cache_ram_slice #(.AW(SLICE_AW), .DW(SLICE_W)) u_slice (
         .clk   (clk),
         .we    (data_we),
         .addr  (data_addr),
         .wdata (word_wdata[d*SLICE_W +: SLICE_W]),
         .rdata (word_rdata[d*SLICE_W +: SLICE_W])
      );
   end

   assign meta_rdata = meta_rpad[META_W-1:0];

   if (META_PAD > META_W) begin : g_pad
      logic [META_PAD-META_W-1:0] pad_unused;
      assign pad_unused = meta_rpad[META_PAD-1:META_W];
   end
endmodule

// File: rtl/cache_fill_ctrl.sv
module cache_fill_ctrl
   import cache_pkg::*;
#(
   parameter int unsigned SET_W  = 13,
   parameter int unsigned TAG_W  = 16,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned META_W = 18
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fill_start,
   input  logic                   fill_way,
   input  logic [TAG_W+SET_W-1:0] fill_blk,
   input  logic [WORD_W-1:0]      fill_word0,
   input  logic [WORD_W-1:0]      fill_word1,
   output logic                   busy,
   output logic                   wr_active,
   output logic [SET_W-1:0]       wr_set,
   output logic                   wr_sel,
   output logic [1:0]             meta_we,
   output logic [1:0]             data_we,
   output logic [META_W-1:0]      wr_meta,
   output logic [WORD_W-1:0]      wr_word
);
   logic                   clearing;
   logic [SET_W-1:0]       clr_idx;
   logic                   pend;
   logic                   pend_way;
   logic [TAG_W+SET_W-1:0] pend_blk;
   logic [WORD_W-1:0]      pend_word;
   logic                   fill_take;
   port_use_e              use_now;

   assign busy      = clearing | pend;
   assign fill_take = fill_start & ~busy;

   always_comb begin
      if (clearing)       use_now = PORT_CLEAR;
      else if (pend)      use_now = PORT_FILL1;
      else if (fill_take) use_now = PORT_FILL0;
      else                use_now = PORT_LOOKUP;
   end

   always_comb begin
      wr_active = 1'b0;
      wr_set    = '0;
      wr_sel    = 1'b0;
      meta_we   = 2'b00;
      data_we   = 2'b00;
      wr_meta   = '0;
      wr_word   = '0;
      unique case (use_now)
         PORT_CLEAR: begin
            wr_active = 1'b1;
            wr_set    = clr_idx;
            meta_we   = 2'b11;
         end
         PORT_FILL1: begin
            wr_active = 1'b1;
            wr_set    = pend_blk[SET_W-1:0];
            wr_sel    = 1'b1;
            meta_we   = 2'b01 << pend_way;
            data_we   = 2'b01 << pend_way;
            wr_meta   = {1'b0, 1'b1, pend_blk[TAG_W+SET_W-1:SET_W]};
            wr_word   = pend_word;
         end
         PORT_FILL0: begin
            wr_active = 1'b1;
            wr_set    = fill_blk[SET_W-1:0];
            meta_we   = 2'b01 << fill_way;
            data_we   = 2'b01 << fill_way;
            wr_meta   = {1'b0, 1'b1, fill_blk[TAG_W+SET_W-1:SET_W]};
            wr_word   = fill_word0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clearing  <= 1'b1;
         clr_idx   <= '0;
         pend      <= 1'b0;
         pend_way  <= 1'b0;
         pend_blk  <= '0;
         pend_word <= '0;
      end else begin
         if (clearing) begin
            clr_idx <= clr_idx + 1'b1;
            if (&clr_idx) clearing <= 1'b0;
         end
         pend <= fill_take;
         if (fill_take) begin
            pend_way  <= fill_way;
            pend_blk  <= fill_blk;
            pend_word <= fill_word1;
         end
      end
   end
endmodule

// File: rtl/two_way_rd_cache.sv
module two_way_rd_cache
   import cache_pkg::*;
#(
   parameter int unsigned ADDR_W   = CACHE_ADDR_W,
   parameter int unsigned WORD_W   = CACHE_WORD_W,
   parameter int unsigned SET_W    = CACHE_SET_W,
   parameter int unsigned SLICE_AW = CACHE_SLICE_AW,
   parameter int unsigned SLICE_W  = CACHE_SLICE_W,
   localparam int unsigned BOFF_W  = $clog2(WORD_W / 8),
   localparam int unsigned TAG_W   = ADDR_W - SET_W - 1 - BOFF_W,
   localparam int unsigned META_W  = TAG_W + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [ADDR_W-1:0]      req_addr,
   output logic                   rsp_valid,
   output logic                   rsp_hit,
   output logic                   rsp_dirty,
   output logic [WORD_W-1:0]      rsp_data,
   input  logic                   fill_start,
   input  logic                   fill_way,
   input  logic [TAG_W+SET_W-1:0] fill_blk,
   input  logic [WORD_W-1:0]      fill_word0,
   input  logic [WORD_W-1:0]      fill_word1,
   output logic                   busy
);
   localparam int unsigned WAYS = 2;

   if (WORD_W % SLICE_W != 0) begin : g_bad_word
      $error("WORD_W must be a multiple of SLICE_W");
   end
   if (SET_W + 1 > SLICE_AW) begin : g_bad_depth
      $error("set index plus word select exceeds slice depth");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the set index");
   end

   logic [TAG_W-1:0]  req_tag;
   logic [SET_W-1:0]  req_set;
   logic              req_sel;
   logic [BOFF_W-1:0] addr_unused;
   logic              req_take;

   assign req_tag     = req_addr[ADDR_W-1 -: TAG_W];
   assign req_set     = req_addr[BOFF_W+1 +: SET_W];
   assign req_sel     = req_addr[BOFF_W];
   assign addr_unused = req_addr[BOFF_W-1:0];

   logic              wr_active, wr_sel;
   logic [SET_W-1:0]  wr_set;
   logic [1:0]        meta_we, data_we;
   logic [META_W-1:0] wr_meta;
   logic [WORD_W-1:0] wr_word;

   cache_fill_ctrl #(
      .SET_W(SET_W), .TAG_W(TAG_W), .WORD_W(WORD_W), .META_W(META_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_start (fill_start),
      .fill_way   (fill_way),
      .fill_blk   (fill_blk),
      .fill_word0 (fill_word0),
      .fill_word1 (fill_word1),
      .busy       (busy),
      .wr_active  (wr_active),
      .wr_set     (wr_set),
      .wr_sel     (wr_sel),
      .meta_we    (meta_we),
      .data_we    (data_we),
      .wr_meta    (wr_meta),
      .wr_word    (wr_word)
   );

   assign req_take = req_valid & ~busy & ~fill_start;

   logic [SET_W-1:0] port_set;
   logic             port_sel;
   assign port_set = wr_active ? wr_set : req_set;
   assign port_sel = wr_active ? wr_sel : req_sel;

   logic             look_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         look_q <= 1'b0;
         tag_q  <= '0;
      end else begin
         look_q <= req_take;
         if (req_take) tag_q <= req_tag;
      end
   end

   logic [META_W-1:0] meta_rd [WAYS];
   logic [WORD_W-1:0] word_rd [WAYS];
   logic [WAYS-1:0]   way_hit;
   logic [WAYS-1:0]   way_dirty;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      cache_way #(
         .SET_W(SET_W), .META_W(META_W), .WORD_W(WORD_W),
         .SLICE_AW(SLICE_AW), .SLICE_W(SLICE_W)
      ) u_way (
         .clk        (clk),
         .meta_we    (meta_we[w]),
         .data_we    (data_we[w]),
         .set_idx    (port_set),
         .word_sel   (port_sel),
         .meta_wdata (wr_meta),
         .word_wdata (wr_word),
         .meta_rdata (meta_rd[w]),
         .word_rdata (word_rd[w])
      );

      assign way_hit[w]   = look_q & meta_rd[w][TAG_W] &
                            (meta_rd[w][TAG_W-1:0] == tag_q);
      assign way_dirty[w] = meta_rd[w][TAG_W+1];
   end

   always_comb begin
      rsp_data  = '0;
      rsp_dirty = 1'b0;
      if (way_hit[0]) begin
         rsp_data  = word_rd[0];
         rsp_dirty = way_dirty[0];
      end else if (way_hit[1]) begin
         rsp_data  = word_rd[1];
         rsp_dirty = way_dirty[1];
      end
   end

   assign rsp_valid = look_q;
   assign rsp_hit   = |way_hit;
endmodule

// File: rtl/cache_rd_chk.sv
module cache_rd_chk #(
   parameter int unsigned SET_W  = 13,
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              fill_start,
   input logic              busy,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_dirty,
   input logic [WORD_W-1:0] rsp_data,
   input logic [1:0]        way_hit
);
   localparam int unsigned SETS = 1 << SET_W;

   logic [SET_W+1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst <= (SET_W+2)'(SETS)) since_rst <= since_rst + 1'b1;
   end

   AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < (SET_W+2)'(SETS)) |-> busy); // R5
   AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == (SET_W+2)'(SETS)) |-> !busy); // R5
   AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !fill_start) |=> rsp_valid); // R2
   AST_REQ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || busy || fill_start) |=> !rsp_valid); // R6
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_data == '0 && !rsp_dirty)); // R4
   AST_HIT_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid); // R4
   AST_FILL_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_start && !busy) |=> busy); // R7
   AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> !rsp_dirty); // R7
   AST_WAY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_hit)); // R9
endmodule

bind two_way_rd_cache cache_rd_chk #(.SET_W(SET_W), .WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .fill_start (fill_start),
   .busy       (busy),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_dirty  (rsp_dirty),
   .rsp_data   (rsp_data),
   .way_hit    (way_hit)
);

// File: tb/sim_two_way_rd_cache.sv
module sim_two_way_rd_cache;
   localparam int NSETS = 8192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        fill_start = 1'b0;
   logic        fill_way = 1'b0;
   logic [28:0] fill_blk = '0;
   logic [31:0] fill_word0 = '0, fill_word1 = '0;
   logic        rsp_valid, rsp_hit, rsp_dirty, busy;
   logic [31:0] rsp_data;

   always #10 clk = ~clk;

   two_way_rd_cache u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
      .rsp_data(rsp_data), .fill_start(fill_start), .fill_way(fill_way),
      .fill_blk(fill_blk), .fill_word0(fill_word0), .fill_word1(fill_word1),
      .busy(busy)
   );

   int    n_chk = 0, n_bad = 0, cyc = 0;
   bit    checking = 1'b0;
   string scen = "R5";

   // reference model: keys are way*NSETS+set, data keys add the word select
   bit [15:0] m_tag [int];
   bit [31:0] m_dat [int];
   int        clr_left = NSETS;
   bit        pend = 1'b0;
   int        pend_key = 0;
   bit [31:0] pend_word = '0;
   bit        e_valid = 1'b0, e_hit = 1'b0, e_busy = 1'b1;
   bit [31:0] e_data = '0;

   function automatic int lookup_way(bit [15:0] t, int s);
      for (int w = 0; w < 2; w++)
         if (m_tag.exists(w*NSETS+s) && m_tag[w*NSETS+s] == t) return w;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tag.delete(); m_dat.delete();
         clr_left = NSETS; pend = 1'b0;
         e_valid = 1'b0; e_hit = 1'b0; e_data = '0; e_busy = 1'b1;
      end else begin
         bit mbusy, racc, facc;
         int s, w, k;
         mbusy = (clr_left > 0) || pend;
         racc  = req_valid && !mbusy && !fill_start;
         facc  = fill_start && !mbusy;
         e_valid = racc; e_hit = 1'b0; e_data = '0;
         if (racc) begin
            s = int'(req_addr[15:3]);
            w = lookup_way(req_addr[31:16], s);
            if (w >= 0) begin
               e_hit  = 1'b1;
               e_data = m_dat.exists((w*NSETS+s)*2+req_addr[2]) ?
                        m_dat[(w*NSETS+s)*2+req_addr[2]] : 32'h0;
            end
         end
         if (clr_left > 0) clr_left--;
         if (pend) begin
            m_dat[pend_key*2+1] = pend_word;
            pend = 1'b0;
         end
         if (facc) begin
            k = int'(fill_way)*NSETS + int'(fill_blk[12:0]);
            m_tag[k] = fill_blk[28:13];
            m_dat[k*2] = fill_word0;
            pend = 1'b1; pend_key = k; pend_word = fill_word1;
         end
         e_busy = (clr_left > 0) || pend;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (checking && rst_n) begin
         check("R5 busy", 32'(busy), 32'(e_busy));
         check({"R2/R6 rsp_valid ", scen}, 32'(rsp_valid), 32'(e_valid));
         check({"R3 rsp_hit ", scen}, 32'(rsp_hit), 32'(e_hit));
         check({"R3/R4 rsp_data ", scen}, rsp_data, e_data);
         check("R7 rsp_dirty", 32'(rsp_dirty), 32'h0);
      end
   end

   task automatic rd(logic [31:0] a);
      @(negedge clk); req_valid = 1'b1; req_addr = a;
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic fill(bit w, logic [15:0] t, logic [12:0] s, logic [31:0] d0, logic [31:0] d1);
      @(negedge clk);
      fill_start = 1'b1; fill_way = w; fill_blk = {t, s}; fill_word0 = d0; fill_word1 = d1;
      @(negedge clk); fill_start = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [31:0] ad(logic [15:0] t, logic [12:0] s, bit ws, logic [1:0] b);
      return {t, s, ws, b};
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R5 busy in reset", 32'(busy), 32'h1);
      check("R4 rsp_valid in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      while (busy) @(negedge clk);
   endtask

   initial begin
      do_reset();
      checking = 1'b1;
      scen = "R5"; // everything misses after the clear
      rd(ad(16'h0000, 13'd0, 0, 0)); rd(ad(16'hFFFF, 13'd8191, 1, 0));

      scen = "R1"; // word select picks first or second word
      fill(0, 16'hABCD, 13'd5, 32'h1111_0000, 32'h2222_0001);
      rd(ad(16'hABCD, 13'd5, 0, 0)); rd(ad(16'hABCD, 13'd5, 1, 0));
      scen = "R10"; // byte offset ignored
      rd(ad(16'hABCD, 13'd5, 1, 3)); rd(ad(16'hABCD, 13'd5, 0, 2));
      scen = "R9";
      fill(1, 16'h1234, 13'd5, 32'h3333_0000, 32'h4444_0001);
      rd(ad(16'h1234, 13'd5, 0, 0)); rd(ad(16'hABCD, 13'd5, 1, 0));
      scen = "R8"; // replace way 0, way 1 stays
      fill(0, 16'h7777, 13'd5, 32'h5555_0000, 32'h6666_0001);
      rd(ad(16'hABCD, 13'd5, 0, 0)); rd(ad(16'h1234, 13'd5, 1, 0));
      rd(ad(16'h7777, 13'd5, 1, 1)); rd(ad(16'h7777, 13'd4, 0, 0));
      scen = "R3"; // boundary sets and tags
      fill(1, 16'hFFFF, 13'd8191, 32'hDEAD_BEEF, 32'hCAFE_F00D);
      fill(0, 16'h0000, 13'd0, 32'h0, 32'hFFFF_FFFF);
      rd(ad(16'hFFFF, 13'd8191, 1, 0)); rd(ad(16'h0000, 13'd0, 1, 0));
      rd(ad(16'h0000, 13'd0, 0, 0)); rd(ad(16'hFFFE, 13'd8191, 0, 0));

      scen = "R6"; // request together with fill_start, then during second beat
      @(negedge clk);
      req_valid = 1'b1; req_addr = ad(16'hABCD, 13'd9, 0, 0);
      fill_start = 1'b1; fill_way = 1'b0; fill_blk = {16'hABCD, 13'd9};
      fill_word0 = 32'hA0; fill_word1 = 32'hA1;
      @(negedge clk); fill_start = 1'b0;
      @(negedge clk); req_valid = 1'b0;
      rd(ad(16'hABCD, 13'd9, 1, 0));

      scen = "R7"; // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         int act, s;
         bit w;
         logic [15:0] t;
         act = $urandom_range(0, 3);
         s = ($urandom_range(0, 9) == 0) ? 8191 : $urandom_range(0, 7);
         t = 16'h1000 + 16'($urandom_range(0, 3));
         w = 1'($urandom_range(0, 1));
         @(negedge clk);
         req_valid = 1'b0; fill_start = 1'b0;
         if (act != 0) begin
            req_valid = 1'b1; req_addr = ad(t, 13'(s), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
         end
         if (act == 0 || act == 3) begin
            int o;
            o = (1 - int'(w))*NSETS + s;
            if (!(m_tag.exists(o) && m_tag[o] == t)) begin
               fill_start = 1'b1; fill_way = w; fill_blk = {t, 13'(s)};
               fill_word0 = $urandom; fill_word1 = $urandom;
            end
         end
      end
      @(negedge clk); req_valid = 1'b0; fill_start = 1'b0;
      repeat (3) @(negedge clk);

      scen = "R5"; // a new reset forgets earlier fills
      checking = 1'b0;
      do_reset();
      checking = 1'b1;
      rd(ad(16'h1234, 13'd5, 0, 0)); rd(ad(16'hFFFF, 13'd8191, 1, 0));
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule